// File: doc/BRIEF.md
# Load-Level CPU Clock Selector

This block decides which clock source, divider and clock-select bit drive the CPU clock generator. When dynamic frequency scaling is on, one of four performance load levels is active; the level number taken from a load word picks one of two configuration words and one 16-bit half of that word, and the source, divider and select fields are unpacked from that half. When scaling is off, the block ignores the level configurations and takes the source and divider from two fixed-setting words instead.

Next to the selection path, the block answers divider lookups: a requester presents a divider value and a request strobe, and one cycle later gets a valid strobe with either the lowest-numbered level whose stored divider equals the request, or an error flag. Clock switching policy and supply voltage control sit outside this block; the configuration words arrive as plain inputs from the surrounding register file.

Top module: `dvfs_clk_sel`

## Requirements
- R1: While rst_n is low, and at the first sample after it, cpu_src_o, cpu_div_o, cpu_alt_o, lk_valid_o, lk_err_o and lk_lvl_o are all zero.
- R2: Dynamic scaling is on exactly when bit 31 of mode_word is 1; the other bits of mode_word have no effect.
- R3: The active level is load_word[1:0] (upper bits ignored); levels 0 and 1 take their configuration from lvl01_word, levels 2 and 3 from lvl23_word.
- R4: Levels 0 and 2 use bits [31:16] of their word; levels 1 and 3 use bits [15:0].
- R5: Inside a 16-bit level configuration the divider is bits [15:13], the clock-select bit is bit 11 and the source is bits [10:9]; bit 12 and bits [8:0] are ignored.
- R6: With scaling off, cpu_src_o is fix_sel_word[23:22], cpu_div_o is fix_div_word[30:28] except that the value 7 is reported as 0, and cpu_alt_o is 0.
- R7: cpu_src_o, cpu_div_o and cpu_alt_o reflect the inputs sampled at the previous rising clock edge.
- R8: lk_valid_o is 1 in the cycle after each cycle in which lk_req_i is 1, and 0 after a cycle without a request; with no request lk_err_o and lk_lvl_o are 0.
- R9: With scaling on, a lookup compares lk_div_i with the stored divider of levels 0, 1, 2, 3 in that order and returns the first equal level on lk_lvl_o with lk_err_o at 0.
- R10: With scaling on and no level matching, the lookup returns lk_err_o at 1 and lk_lvl_o at 0.
- R11: A lookup made while scaling is off returns lk_err_o at 1 and lk_lvl_o at 0, whatever the stored dividers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl01_word | input | 32 | Configuration word for levels 0 (upper half) and 1 (lower half) |
| lvl23_word | input | 32 | Configuration word for levels 2 (upper half) and 3 (lower half) |
| mode_word | input | 32 | Mode word; bit 31 enables dynamic scaling |
| load_word | input | 32 | Load word; bits [1:0] give the active level |
| fix_sel_word | input | 32 | Fixed-setting word holding the static source in bits [23:22] |
| fix_div_word | input | 32 | Fixed-setting word holding the static divider in bits [30:28] |
| lk_req_i | input | 1 | Divider lookup request |
| lk_div_i | input | 3 | Divider value to look up |
| cpu_src_o | output | 2 | Selected clock source |
| cpu_div_o | output | 3 | Selected divider |
| cpu_alt_o | output | 1 | Selected clock-select bit |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_err_o | output | 1 | Lookup found no level, or scaling is off |
| lk_lvl_o | output | 2 | Level found by the lookup |

## Verification
The bench loads distinct settings into all four levels, with noise in every bit outside the decoded fields, so a design that swaps the two words, picks the wrong half, or decodes a field one bit off returns a visibly different source or divider. A divider stored in both level 1 and level 3 catches a search that returns the last match rather than the first. Lookups while scaling is off, and a static divider of 7, catch a design that searches anyway or passes the out-of-range divider through. Back-to-back and idle request cycles catch a valid strobe that sticks or slips a cycle.

// File: rtl/dvfs_sel_pkg.sv
package dvfs_sel_pkg;

    localparam int unsigned SRC_W   = 2;
    localparam int unsigned DIV_W   = 3;
    localparam int unsigned NUM_LVL = 4;
    localparam int unsigned LVL_W   = $clog2(NUM_LVL);

    // One decoded level configuration (or the static fallback).
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             alt;
        logic [SRC_W-1:0] src;
    } lvl_cfg_t;

    // Everything the top registers each cycle.
    typedef struct packed {
        lvl_cfg_t         cur;
        logic             lk_valid;
        logic             lk_err;
        logic [LVL_W-1:0] lk_lvl;
    } sel_state_t;

endpackage

// File: rtl/dvfs_lvl_unpack.sv
module dvfs_lvl_unpack
    import dvfs_sel_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned DIV_LSB = 13,
    parameter int unsigned ALT_LSB = 11,
    parameter int unsigned SRC_LSB = 9
) (
    input  logic [WORD_W-1:0]              pair_a_i,
    input  logic [WORD_W-1:0]              pair_b_i,
    output lvl_cfg_t [NUM_LVL-1:0]         cfg_o
);

    localparam int unsigned HALF_W    = WORD_W / 2;
    localparam int unsigned LVL_PER_W = 2;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        localparam bit USE_B    = (g / LVL_PER_W) != 0;
        localparam bit UPPER_HF = (g % LVL_PER_W) == 0;

        logic [WORD_W-1:0] word_w;
        logic [HALF_W-1:0] half_w;

        if (USE_B) begin : g_wb
            assign word_w = pair_b_i;
        end else begin : g_wa
            assign word_w = pair_a_i;
        end

        if (UPPER_HF) begin : g_up
            assign half_w = word_w[WORD_W-1 -: HALF_W];
        end else begin : g_lo
            assign half_w = word_w[HALF_W-1:0];
        end

        assign cfg_o[g].div = half_w[DIV_LSB +: DIV_W];
        assign cfg_o[g].alt = half_w[ALT_LSB];
        assign cfg_o[g].src = half_w[SRC_LSB +: SRC_W];
    end

endmodule

// File: rtl/dvfs_div_search.sv
module dvfs_div_search
    import dvfs_sel_pkg::*;
(
    input  lvl_cfg_t [NUM_LVL-1:0] cfg_i,
    input  logic [DIV_W-1:0]       want_i,
    output logic                   hit_o,
    output logic [LVL_W-1:0]       lvl_o
);

    logic [NUM_LVL-1:0] eq_w;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_cmp
        assign eq_w[g] = (cfg_i[g].div == want_i);
    end

    // Scan from the top down so the lowest matching level is written last.
    always_comb begin
        hit_o = 1'b0;
        lvl_o = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (eq_w[i]) begin
                hit_o = 1'b1;
                lvl_o = LVL_W'(i);
            end
        end
    end

    // R9: no level below the returned one may hold the requested divider.
    always_comb begin
        if (hit_o) begin
            for (int j = 0; j < NUM_LVL; j++) begin
                if (j < int'(lvl_o)) begin
                    assert_first_match_R9: assert (cfg_i[j].div != want_i)
                        else $error("lookup skipped lower matching level");
                end
            end
        end
    end

endmodule

// File: rtl/dvfs_src_pick.sv
module dvfs_src_pick
    import dvfs_sel_pkg::*;
(
    input  lvl_cfg_t [NUM_LVL-1:0] cfg_i,
    input  logic [LVL_W-1:0]       lvl_i,
    input  logic                   dyn_en_i,
    input  logic [SRC_W-1:0]       fix_src_i,
    input  logic [DIV_W-1:0]       fix_div_i,
    output lvl_cfg_t               cur_o
);

    localparam logic [DIV_W-1:0] FIX_DIV_MAX = DIV_W'(6);

    lvl_cfg_t fix_cfg_w;

    always_comb begin
        fix_cfg_w.src = fix_src_i;
        fix_cfg_w.alt = 1'b0;
        fix_cfg_w.div = (fix_div_i > FIX_DIV_MAX) ? '0 : fix_div_i;
    end

    assign cur_o = dyn_en_i ? cfg_i[lvl_i] : fix_cfg_w;

endmodule

// File: rtl/dvfs_clk_sel.sv
module dvfs_clk_sel
    import dvfs_sel_pkg::*;
#(
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned DIV_LSB     = 13,
    parameter int unsigned ALT_LSB     = 11,
    parameter int unsigned SRC_LSB     = 9,
    parameter int unsigned EN_BIT      = 31,
    parameter int unsigned FIX_SRC_LSB = 22,
    parameter int unsigned FIX_DIV_LSB = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] lvl01_word,
    input  logic [WORD_W-1:0] lvl23_word,
    input  logic [WORD_W-1:0] mode_word,
    input  logic [WORD_W-1:0] load_word,
    input  logic [WORD_W-1:0] fix_sel_word,
    input  logic [WORD_W-1:0] fix_div_word,
    input  logic              lk_req_i,
    input  logic [2:0]        lk_div_i,
    output logic [1:0]        cpu_src_o,
    output logic [2:0]        cpu_div_o,
    output logic              cpu_alt_o,
    output logic              lk_valid_o,
    output logic              lk_err_o,
    output logic [1:0]        lk_lvl_o
);

    lvl_cfg_t [NUM_LVL-1:0] cfg_w;
    lvl_cfg_t               cur_w;
    logic                   dyn_en_w;
    logic [LVL_W-1:0]       lvl_w;
    logic                   hit_w;
    logic [LVL_W-1:0]       hit_lvl_w;
    sel_state_t             state_d, state_q;
    logic                   unused_bits;

    assign dyn_en_w = mode_word[EN_BIT];
    assign lvl_w    = load_word[LVL_W-1:0];
    assign unused_bits = ^{mode_word, load_word, fix_sel_word, fix_div_word};

    dvfs_lvl_unpack #(
        .WORD_W  (WORD_W),
        .DIV_LSB (DIV_LSB),
        .ALT_LSB (ALT_LSB),
        .SRC_LSB (SRC_LSB)
    ) u_unpack (
        .pair_a_i (lvl01_word),
        .pair_b_i (lvl23_word),
        .cfg_o    (cfg_w)
    );

    dvfs_src_pick u_pick (
        .cfg_i     (cfg_w),
        .lvl_i     (lvl_w),
        .dyn_en_i  (dyn_en_w),
        .fix_src_i (fix_sel_word[FIX_SRC_LSB +: SRC_W]),
        .fix_div_i (fix_div_word[FIX_DIV_LSB +: DIV_W]),
        .cur_o     (cur_w)
    );

    dvfs_div_search u_search (
        .cfg_i  (cfg_w),
        .want_i (lk_div_i),
        .hit_o  (hit_w),
        .lvl_o  (hit_lvl_w)
    );

    always_comb begin
        state_d          = state_q;
        state_d.cur      = cur_w;
        state_d.lk_valid = lk_req_i;
        state_d.lk_err   = 1'b0;
        state_d.lk_lvl   = '0;
        if (lk_req_i) begin
            if (dyn_en_w && hit_w) begin
                state_d.lk_lvl = hit_lvl_w;
            end else begin
                state_d.lk_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cpu_src_o  = state_q.cur.src;
    assign cpu_div_o  = state_q.cur.div;
    assign cpu_alt_o  = state_q.cur.alt;
    assign lk_valid_o = state_q.lk_valid;
    assign lk_err_o   = state_q.lk_err;
    assign lk_lvl_o   = state_q.lk_lvl;

    // R8: one valid strobe per request cycle, none otherwise
    assert_valid_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req_i |=> lk_valid_o);
    assert_no_stray_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req_i |=> (!lk_valid_o && !lk_err_o && lk_lvl_o == '0));

    // R11: lookups with scaling off are rejected
    assert_static_reject_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req_i && !mode_word[EN_BIT]) |=> (lk_err_o && lk_lvl_o == '0));

    // R6: static fallback never reports divider 7 and keeps the select bit low
    assert_static_div_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_word[EN_BIT] |=> (cpu_div_o != 3'd7 && !cpu_alt_o));

    // R10: an error result always carries level zero
    assert_err_level_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_err_o |-> (lk_valid_o && lk_lvl_o == '0));

endmodule

// File: tb/tb_dvfs_clk_sel.sv
`timescale 1ns/1ps
module tb_dvfs_clk_sel;

    typedef struct packed {
        logic [1:0] src;
        logic [2:0] div;
        logic       alt;
        logic       vld;
        logic       err;
        logic [1:0] lvl;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lvl01_word = '0, lvl23_word = '0, mode_word = '0, load_word = '0;
    logic [31:0] fix_sel_word = '0, fix_div_word = '0;
    logic        lk_req_i = 1'b0;
    logic [2:0]  lk_div_i = '0;
    logic [1:0]  cpu_src_o;
    logic [2:0]  cpu_div_o;
    logic        cpu_alt_o, lk_valid_o, lk_err_o;
    logic [1:0]  lk_lvl_o;

    int checks = 0;
    int errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    bit    done = 0;

    always #2.5 clk = ~clk;

    dvfs_clk_sel dut (
        .clk(clk), .rst_n(rst_n),
        .lvl01_word(lvl01_word), .lvl23_word(lvl23_word),
        .mode_word(mode_word), .load_word(load_word),
        .fix_sel_word(fix_sel_word), .fix_div_word(fix_div_word),
        .lk_req_i(lk_req_i), .lk_div_i(lk_div_i),
        .cpu_src_o(cpu_src_o), .cpu_div_o(cpu_div_o), .cpu_alt_o(cpu_alt_o),
        .lk_valid_o(lk_valid_o), .lk_err_o(lk_err_o), .lk_lvl_o(lk_lvl_o)
    );

    // 16-bit level setting with noise in bit 12 and bits 8:0
    function automatic logic [15:0] mk(input logic [2:0] d, input logic a, input logic [1:0] s);
        return {d, 1'b1, a, s, 9'h15A};
    endfunction

    function automatic logic [15:0] half_of(input int l);
        logic [31:0] w;
        w = (l >= 2) ? lvl23_word : lvl01_word;
        return (l % 2 == 0) ? w[31:16] : w[15:0];
    endfunction

    function automatic exp_t model();
        exp_t e;
        logic [15:0] h;
        bit found;
        e = '0;
        if (mode_word[31]) begin
            h = half_of(int'(load_word[1:0]));
            e.div = h[15:13];
            e.alt = h[11];
            e.src = h[10:9];
        end else begin
            e.src = fix_sel_word[23:22];
            e.div = (fix_div_word[30:28] == 3'd7) ? 3'd0 : fix_div_word[30:28];
            e.alt = 1'b0;
        end
        if (lk_req_i) begin
            e.vld = 1'b1;
            found = 0;
            if (mode_word[31]) begin
                for (int i = 0; i < 4; i++) begin
                    h = half_of(i);
                    if (!found && h[15:13] == lk_div_i) begin
                        found = 1;
                        e.lvl = 2'(i);
                    end
                end
            end
            e.err = !found;
        end
        return e;
    endfunction

    // Driver: apply inputs at the falling edge, queue what the next rising edge must produce
    task automatic step(input string tag);
        exp_q.push_back(model());
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compare just after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            exp_t e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {cpu_src_o, cpu_div_o, cpu_alt_o, lk_valid_o, lk_err_o, lk_lvl_o};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s src/div/alt/vld/err/lvl actual %0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d",
                         t, a.src, a.div, a.alt, a.vld, a.err, a.lvl,
                         e.src, e.div, e.alt, e.vld, e.err, e.lvl);
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        // Busy inputs during reset must not reach the outputs (R1)
        lvl01_word   = {mk(3'd1, 1'b0, 2'd2), mk(3'd2, 1'b1, 2'd1)};
        lvl23_word   = {mk(3'd4, 1'b0, 2'd3), mk(3'd2, 1'b1, 2'd0)};
        mode_word    = 32'h8000_0000;
        load_word    = 32'hFFFF_FFFE;
        lk_req_i     = 1'b1;
        lk_div_i     = 3'd4;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({cpu_src_o, cpu_div_o, cpu_alt_o, lk_valid_o, lk_err_o, lk_lvl_o} !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %b expected 0",
                     {cpu_src_o, cpu_div_o, cpu_alt_o, lk_valid_o, lk_err_o, lk_lvl_o});
        end
        @(negedge clk);
        lk_req_i = 1'b0;
        rst_n = 1'b1;

        // R3 R4 R5 R2: each level with scaling on, noisy mode and load upper bits
        mode_word = 32'hC5A5_0F0F;
        for (int l = 0; l < 4; l++) begin
            load_word = 32'hFFFF_FFFC | 32'(l);
            step("R3_R4_R5 level decode");
        end
        // R7: outputs track a change one cycle later
        load_word = 32'h0000_0001;
        step("R7 level change");
        lvl01_word = {mk(3'd6, 1'b1, 2'd3), mk(3'd5, 1'b0, 2'd2)};
        step("R7 word change");
        lvl01_word = {mk(3'd1, 1'b0, 2'd2), mk(3'd2, 1'b1, 2'd1)};

        // R6 R2: fallback with scaling off, other mode bits all set
        mode_word    = 32'h7FFF_FFFF;
        fix_sel_word = 32'h5A3B_3C4D;
        fix_div_word = 32'h3FFF_FFFF;
        step("R6 static fields");
        fix_div_word = 32'hF0A5_5A5A;
        fix_sel_word = 32'h0080_0000;
        step("R6 static div 7 reads 0");

        // R11: lookups rejected with scaling off
        lk_req_i = 1'b1;
        lk_div_i = 3'd1;
        step("R11 lookup while static");
        lk_div_i = 3'd4;
        step("R11 lookup while static");

        // R9 R10 R8: lookups with scaling on, back to back
        mode_word = 32'h8000_0000;
        load_word = 32'h0000_0003;
        lk_div_i = 3'd1;
        step("R9 match level 0");
        lk_div_i = 3'd2;
        step("R9 first of levels 1 and 3");
        lk_div_i = 3'd4;
        step("R9 match level 2");
        lk_div_i = 3'd5;
        step("R10 no match");
        lk_div_i = 3'd0;
        step("R10 no match zero");
        lk_req_i = 1'b0;
        lk_div_i = 3'd2;
        step("R8 idle after request");
        step("R8 idle");
        lk_req_i = 1'b1;
        lvl01_word = {mk(3'd3, 1'b0, 2'd0), mk(3'd7, 1'b1, 2'd1)};
        lvl23_word = {mk(3'd3, 1'b1, 2'd2), mk(3'd7, 1'b0, 2'd3)};
        lk_div_i = 3'd7;
        step("R9 first of levels 1 and 3 new words");
        lk_div_i = 3'd3;
        step("R9 first of levels 0 and 2");
        lk_req_i = 1'b0;
        step("R8 idle final");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 results missing actual %0d expected 0", exp_q.size());
        end
        done = 1;
        summary();
    end

endmodule